// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog peripheral on a simple 16-bit write/read strobe port. Software programs a timeout in half-second units and then sets a write-once run bit. From then on the block counts down on a slow half-second tick-enable input. The count is restored only when the service register receives an ordered pair of key words. If the countdown reaches its end, the block raises a one-cycle reset request for the system reset tree.

A second, fixed 16-second counter runs from reset and also raises the reset request when it ends. Software stops it for good by writing zero to the miscellaneous register. A status register keeps the cause of the most recent reset. That cause is a watchdog expiry, a power-on, or one of two external reset events that the block receives as pulses. The status register survives the ordinary system reset and is cleared only by power-on.

Top module: `kwdt_top`

## Requirements
- R1: Register decode on `addr_i` byte offsets. 0x0 is control: reads return the timeout in bits [15:8], the external-assert control in bit 5, the software-reset control in bit 4 and the run bit in bit 2, with all other bits zero. 0x2 is service and reads zero. 0x4 is status. 0x8 is miscellaneous: bit 0 reads 1 while the power-down counter is armed. Any other offset reads zero.
- R2: With timeout field N, the watchdog expires on the (N+1)-th tick after it starts or reloads. `rst_req_o` is high for exactly the one cycle that follows the clock edge that took the expiring tick. After expiry the count reloads from the field.
- R3: The run bit can only be set. Writing control with bit 2 clear does not clear it, and only reset clears it. The write that sets it loads the count from the timeout carried in that same write.
- R4: While the watchdog runs, a new timeout written to control does not disturb the countdown in progress. It is used from the next reload onward.
- R5: Writing 0x5555 and then 0xAAAA to the service register reloads the count to N+1.
- R6: A service write of 0xAAAA that does not directly follow 0x5555 does not reload the count. Any other value written to service cancels a pending 0x5555.
- R7: An expiry sets status to 0x0002, which is the watchdog bit alone.
- R8: Power-on reset (`por_n` low) sets status to 0x0010, the cold-start bit alone, and clears control. A system reset (`rst_n` low) leaves status unchanged.
- R9: A `hard_rst_i` pulse sets status to 0x0008 and a `warm_rst_i` pulse sets it to 0x0001. The priority is expiry, then hard, then warm.
- R10: After reset the power-down counter requests a reset on the 32nd tick and then restarts. Writing 0x0000 to miscellaneous disables it until reset. Nonzero writes have no effect.
- R11: While the run bit is clear and the power-down counter is disabled, `rst_req_o` stays low whatever the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, asynchronous, active low; status kept |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tick_i | input | 1 | Half-second tick enable |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| hard_rst_i | input | 1 | External hard-reset event pulse |
| warm_rst_i | input | 1 | External warm-reset event pulse |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest situations to reach are the ones where the key checker and the countdown interact. Examples are a lone 0xAAAA, or a stray value placed between the two keys, arriving a tick or two before expiry, where the only visible sign of a wrong reload is a request that comes early or late. The stimulus first disables the power-down counter so that its requests cannot mask the main counter. It then enables the watchdog, spends a known number of ticks, and places each key sequence at a chosen distance from expiry. A behavioural model runs alongside and predicts the request cycle and every readback on each clock. The same method puts a timeout rewrite in the middle of a countdown to show that the new value takes effect only at the next reload.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int REG_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_SVC  = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_MISC = 4'h8;

    localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

    localparam int CTRL_RUN = 2;
    localparam int CTRL_SRS = 4;
    localparam int CTRL_EXT = 5;

    localparam int ST_WARM = 0;
    localparam int ST_WDOG = 1;
    localparam int ST_HARD = 3;
    localparam int ST_COLD = 4;

    typedef struct packed {
        logic [7:0] tmo;
        logic       run;
        logic       srs;
        logic       ext;
        logic       pd_en;
        logic       req;
    } ctrl_t;
endpackage

// File: rtl/kwdt_down.sv
module kwdt_down #(
    parameter int W = 9,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && tick_i) begin
            if (cnt_q == W'(1)) begin
                expire_o = 1'b1;
                cnt_d    = load_val_i;
            end else begin
                cnt_d = cnt_q - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] data_i,
    output logic             fire_o,
    output logic             armed_o
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        fire_o  = 1'b0;
        if (wr_i) begin
            fire_o  = armed_q && (data_i == KEY_FIRE);
            armed_d = (data_i == KEY_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int TMO_W    = 8,
    parameter int PD_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              hard_rst_i,
    input  logic              warm_rst_i,
    output logic              rst_req_o
);
    localparam int CNT_W = TMO_W + 1;
    localparam int PD_W  = $clog2(PD_TICKS + 1);

    ctrl_t            st_d, st_q;
    logic [REG_W-1:0] status_d, status_q;
    logic             rst_all_n;
    logic             wr_ctrl, wr_svc, wr_misc;
    logic             run_rise, fire, key_armed;
    logic             main_load, main_exp, pd_exp;
    logic [TMO_W-1:0] new_tmo;
    logic [CNT_W-1:0] main_val;

    assign rst_all_n = rst_n & por_n;
    assign wr_ctrl   = wr_i && (addr_i == OFF_CTRL);
    assign wr_svc    = wr_i && (addr_i == OFF_SVC);
    assign wr_misc   = wr_i && (addr_i == OFF_MISC);
    assign new_tmo   = wdata_i[REG_W-1 -: TMO_W];
    assign run_rise  = wr_ctrl && wdata_i[CTRL_RUN] && !st_q.run;
    assign main_load = run_rise || fire;
    assign main_val  = run_rise ? ({1'b0, new_tmo} + CNT_W'(1))
                                : ({1'b0, st_q.tmo} + CNT_W'(1));

    kwdt_keyseq u_key (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .wr_i    (wr_svc),
        .data_i  (wdata_i),
        .fire_o  (fire),
        .armed_o (key_armed)
    );

    kwdt_down #(.W(CNT_W), .RST_VAL('0)) u_main (
        .clk        (clk),
        .rst_n      (rst_all_n),
        .run_i      (st_q.run),
        .tick_i     (tick_i),
        .load_i     (main_load),
        .load_val_i (main_val),
        .expire_o   (main_exp)
    );

    kwdt_down #(.W(PD_W), .RST_VAL(PD_W'(PD_TICKS))) u_pd (
        .clk        (clk),
        .rst_n      (rst_all_n),
        .run_i      (st_q.pd_en),
        .tick_i     (tick_i),
        .load_i     (1'b0),
        .load_val_i (PD_W'(PD_TICKS)),
        .expire_o   (pd_exp)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = main_exp || pd_exp;
        if (wr_ctrl) begin
            st_d.tmo = new_tmo;
            st_d.run = st_q.run | wdata_i[CTRL_RUN];
            st_d.srs = wdata_i[CTRL_SRS];
            st_d.ext = wdata_i[CTRL_EXT];
        end
        if (wr_misc && (wdata_i == '0)) st_d.pd_en = 1'b0;

        status_d = status_q;
        if (main_exp || pd_exp) status_d = REG_W'(1) << ST_WDOG;
        else if (hard_rst_i)    status_d = REG_W'(1) << ST_HARD;
        else if (warm_rst_i)    status_d = REG_W'(1) << ST_WARM;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            st_q       <= '0;
            st_q.pd_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) status_q <= REG_W'(1) << ST_COLD;
        else        status_q <= status_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_CTRL: begin
                rdata_o[REG_W-1 -: TMO_W] = st_q.tmo;
                rdata_o[CTRL_EXT]         = st_q.ext;
                rdata_o[CTRL_SRS]         = st_q.srs;
                rdata_o[CTRL_RUN]         = st_q.run;
            end
            OFF_STAT: rdata_o = status_q;
            OFF_MISC: rdata_o[0] = st_q.pd_en;
            default:  rdata_o = '0;
        endcase
    end

    assign rst_req_o = st_q.req;
endmodule

// File: rtl/kwdt_sva.sv
module kwdt_sva
    import kwdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             svc_wr,
    input logic [REG_W-1:0] wdata,
    input logic             run_q,
    input logic             pd_en_q,
    input logic             armed,
    input logic             rst_req,
    input logic [REG_W-1:0] status_q
);
    AST_RUN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q); // R3
    AST_PD_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en_q |=> !pd_en_q); // R10
    AST_REQ_MARKS_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (status_q == 16'h0002)); // R7
    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick_i)); // R2
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !pd_en_q) |=> !rst_req); // R11
    AST_ARM_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(svc_wr && (wdata == KEY_ARM))); // R5
    AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_q)); // R9
endmodule

bind kwdt_top kwdt_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_all_n),
    .tick_i   (tick_i),
    .svc_wr   (wr_svc),
    .wdata    (wdata_i),
    .run_q    (st_q.run),
    .pd_en_q  (st_q.pd_en),
    .armed    (key_armed),
    .rst_req  (rst_req_o),
    .status_q (status_q)
);

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        tick = 1'b0, wr = 1'b0, hard = 1'b0, warm = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        req;

    int nchk = 0, nfail = 0, req_cnt = 0, cyc = 0;
    bit chk_on = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [7:0]  m_tmo;
    logic        m_run, m_srs, m_ext, m_pd, m_arm, m_req;
    int          m_cnt, m_pdc;
    logic [15:0] m_stat;

    always #4 clk = ~clk;

    kwdt_top u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_i(tick),
        .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .hard_rst_i(hard), .warm_rst_i(warm), .rst_req_o(req)
    );

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return {m_tmo, 2'b00, m_ext, m_srs, 1'b0, m_run, 2'b00};
            4'h4: return m_stat;
            4'h8: return {15'd0, m_pd};
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ex;
        ex = 0;
        if (!rst_n || !por_n) begin
            m_tmo = 0; m_run = 0; m_srs = 0; m_ext = 0; m_pd = 1;
            m_arm = 0; m_cnt = 0; m_pdc = 32;
        end else begin
            bit fire, rise;
            fire = wr && addr == 4'h2 && wdata == 16'hAAAA && m_arm;
            rise = wr && addr == 4'h0 && wdata[2] && !m_run;
            if (rise) m_cnt = int'(wdata[15:8]) + 1;
            else if (fire) m_cnt = int'(m_tmo) + 1;
            else if (m_run && tick) begin
                if (m_cnt == 1) begin ex = 1; m_cnt = int'(m_tmo) + 1; end
                else m_cnt--;
            end
            if (m_pd && tick) begin
                if (m_pdc == 1) begin ex = 1; m_pdc = 32; end
                else m_pdc--;
            end
            if (wr && addr == 4'h0) begin
                m_tmo = wdata[15:8]; m_srs = wdata[4]; m_ext = wdata[5];
                m_run = m_run | wdata[2];
            end
            if (wr && addr == 4'h8 && wdata == 16'h0000) m_pd = 0;
            if (wr && addr == 4'h2) m_arm = (wdata == 16'h5555);
        end
        m_req = ex;
        if (!por_n) m_stat = 16'h0010;
        else if (ex) m_stat = 16'h0002;
        else if (hard) m_stat = 16'h0008;
        else if (warm) m_stat = 16'h0001;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check({cur_req, " request"}, {15'd0, req}, {15'd0, m_req});
            check({cur_req, " readback"}, rdata, m_read(addr));
        end
        if (req === 1'b1) req_cnt++;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
            finish_run();
        end
    end

    task automatic step(input bit t, input bit w, input logic [3:0] a,
                        input logic [15:0] d, input bit h, input bit wm);
        @(negedge clk); #1;
        tick = t; wr = w; addr = a; wdata = d; hard = h; warm = wm;
    endtask
    task automatic idle(); step(0, 0, addr, 16'h0, 0, 0); endtask
    task automatic tickn(input int n);
        for (int i = 0; i < n; i++) begin step(1, 0, addr, 16'h0, 0, 0); idle(); end
        idle();
    endtask
    task automatic wreg(input logic [3:0] a, input logic [15:0] d);
        step(0, 1, a, d, 0, 0); idle();
    endtask
    task automatic rdchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
        step(0, 0, a, 16'h0, 0, 0);
        @(negedge clk);
        check(tag, rdata, exp);
    endtask
    task automatic cnt_chk(input string tag, input int exp);
        check(tag, 16'(req_cnt), 16'(exp));
    endtask
    task automatic do_reset(input bit power);
        @(negedge clk); #1; rst_n = 0; if (power) por_n = 0;
        repeat (2) @(negedge clk);
        #1; rst_n = 1; por_n = 1;
        idle();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1; rst_n = 1; por_n = 1;
        idle();
        chk_on = 1;
        cur_req = "R8";
        rdchk("R8 cold status", 4'h4, 16'h0010);
        cur_req = "R1";
        rdchk("R1 control reset", 4'h0, 16'h0000);
        rdchk("R1 misc armed", 4'h8, 16'h0001);
        rdchk("R1 service reads zero", 4'h2, 16'h0000);
        rdchk("R1 unmapped reads zero", 4'h6, 16'h0000);

        cur_req = "R10";
        tickn(31);
        cnt_chk("R10 no request before 32 ticks", 0);
        tickn(1);
        cnt_chk("R10 request on 32nd tick", 1);
        cur_req = "R7";
        rdchk("R7 status after expiry", 4'h4, 16'h0002);

        cur_req = "R8";
        do_reset(0);
        rdchk("R8 status kept over system reset", 4'h4, 16'h0002);
        cur_req = "R10";
        wreg(4'h8, 16'h0001);
        tickn(32);
        cnt_chk("R10 nonzero misc write ignored", 2);
        wreg(4'h8, 16'h0000);
        rdchk("R10 misc disabled", 4'h8, 16'h0000);
        cur_req = "R11";
        tickn(40);
        cnt_chk("R11 idle no request", 2);
        wreg(4'h0, 16'h0330);
        tickn(5);
        cnt_chk("R11 run clear no request", 2);
        rdchk("R1 control readback", 4'h0, 16'h0330);

        cur_req = "R2";
        wreg(4'h0, 16'h0334);
        tickn(3);
        cnt_chk("R2 no expiry before N+1", 2);
        tickn(1);
        cnt_chk("R2 expiry at N+1", 3);

        cur_req = "R3";
        wreg(4'h0, 16'h0330);
        rdchk("R3 run bit locked", 4'h0, 16'h0334);

        cur_req = "R5";
        tickn(2);
        wreg(4'h2, 16'h5555);
        wreg(4'h2, 16'hAAAA);
        tickn(3);
        cnt_chk("R5 refresh postpones expiry", 3);
        tickn(1);
        cnt_chk("R5 expiry after refresh", 4);

        cur_req = "R6";
        tickn(2);
        wreg(4'h2, 16'hAAAA);
        tickn(1);
        cnt_chk("R6 lone second key", 4);
        tickn(1);
        cnt_chk("R6 lone second key no reload", 5);
        tickn(2);
        wreg(4'h2, 16'h5555);
        wreg(4'h2, 16'h1234);
        wreg(4'h2, 16'hAAAA);
        tickn(2);
        cnt_chk("R6 interrupted pair no reload", 6);

        cur_req = "R4";
        tickn(1);
        wreg(4'h0, 16'h0134);
        tickn(2);
        cnt_chk("R4 countdown in progress kept", 6);
        tickn(1);
        cnt_chk("R4 old period ends", 7);
        tickn(1);
        cnt_chk("R4 new period pending", 7);
        tickn(1);
        cnt_chk("R4 new period used", 8);

        cur_req = "R9";
        step(0, 0, 4'h4, 16'h0, 1, 0); idle();
        rdchk("R9 hard event", 4'h4, 16'h0008);
        step(0, 0, 4'h4, 16'h0, 0, 1); idle();
        rdchk("R9 warm event", 4'h4, 16'h0001);
        step(0, 0, 4'h4, 16'h0, 1, 1); idle();
        rdchk("R9 hard over warm", 4'h4, 16'h0008);

        cur_req = "R8";
        do_reset(1);
        rdchk("R8 power-on status", 4'h4, 16'h0010);
        rdchk("R8 power-on clears control", 4'h0, 16'h0000);
        rdchk("R10 counter armed after reset", 4'h8, 16'h0001);
        finish_run();
    end
endmodule